// File: doc/BRIEF.md
# Convergent Rounding Right Shifter

This unit divides a signed two's-complement word by a power of two and rounds the quotient to the nearest integer. A quotient exactly halfway between two integers is rounded to whichever of them is even. It is meant for fixed-point datapaths that need to drop fraction bits without the upward bias that plain add-half rounding adds to every tie.

Each request carries an operand, a shift amount and a valid strobe. The result is registered and comes out one cycle later with its own valid strobe.

The rounding increment is chosen before the shift:
- A shift of zero adds nothing.
- If any bit below the half-point position is set, the operand is not a tie, and the increment is one half (weight 2^(n-1)).
- If every bit below the half-point is clear, the increment is the operand's bit n moved down to weight 2^(n-1).
  - When bit n-1 is set, this is an exact tie, and the increment rounds it to even.
  - When bit n-1 is clear, the value is exact, and the increment has no effect.

The operand is sign-extended to twice its width before the increment is added. The sum therefore cannot overflow before it is shifted.

Top module: `rne_shift_right`

## Requirements
- R1: While rst_ni is low and after its release with no request, valid_o is 0 and res_o is 0.
- R2: valid_o is 1 in the cycle after a cycle with valid_i high, and 0 in the cycle after a cycle with valid_i low.
- R3: A shift amount of 0 returns the operand unchanged.
- R4: For shift amount n from 1 to 31, when the discarded fraction is not exactly one half, res_o is the operand divided by 2^n and rounded to the nearest integer. This holds for both signs.
- R5: When the discarded fraction is exactly one half, res_o is the even one of the two nearest integers. This holds for positive and negative operands.
- R6: When the discarded low n bits are all zero, res_o equals the operand arithmetically shifted right by n, with no rounding change.
- R7: While valid_i is low, res_o keeps its last value whatever operand_i and shamt_i do.
- R8: Extreme operands (largest positive and most negative values) produce correctly rounded results with no wrap-around. A non-negative operand never yields a negative result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| operand_i | input | 32 | Signed operand |
| shamt_i | input | 5 | Right shift amount, 0 to 31 |
| valid_o | output | 1 | Result strobe, one cycle after valid_i |
| res_o | output | 32 | Rounded, shifted signed result |

## Verification
Every shift amount is tried with a set of fixed edge operands:
- Zero, plus and minus one, the two extreme values, and alternating bit patterns. These show whether sign extension and wide addition survive at the ends of the range.

Built ties k*2^n + 2^(n-1) for small positive and negative k separate round-half-to-even from round-half-up. They also separate it from round-half-away-from-zero, because odd and even k need opposite decisions.

Exact multiples show that the tie-bit increment never carries when bit n-1 is clear.

Random operands at random shift amounts cover the ordinary nearest-rounding path, which is decided by the sticky bits. A phase with valid_i low and changing inputs shows that the output register holds its value.

// File: rtl/rnd_pkg.sv
package rnd_pkg;
  parameter int unsigned DEF_DATA_W = 32;

  function automatic int unsigned shamt_width(input int unsigned data_w);
    return $clog2(data_w);
  endfunction

  function automatic int unsigned ext_width(input int unsigned data_w);
    return 2 * data_w;
  endfunction
endpackage

// File: rtl/rnd_incr.sv
module rnd_incr #(
  parameter int unsigned DATA_W  = rnd_pkg::DEF_DATA_W,
  localparam int unsigned SH_W   = rnd_pkg::shamt_width(DATA_W),
  localparam int unsigned EXT_W  = rnd_pkg::ext_width(DATA_W)
) (
  input  logic [DATA_W-1:0] operand_i,
  input  logic [SH_W-1:0]   shamt_i,
  output logic [EXT_W-1:0]  incr_o
);
  logic [SH_W-1:0]   half_pos;
  logic [DATA_W-1:0] below_mask;
  logic              sticky;
  logic              even_bit;

  always_comb begin
    half_pos   = shamt_i - SH_W'(1);
    below_mask = (DATA_W'(1) << half_pos) - DATA_W'(1);
    sticky     = |(operand_i & below_mask);
    even_bit   = operand_i[shamt_i];
    if (shamt_i == '0)
      incr_o = '0;
    else if (sticky)
      incr_o = EXT_W'(1) << half_pos;
    else
      incr_o = EXT_W'(even_bit) << half_pos;  // tie: round toward even
  end
endmodule

// File: rtl/rnd_shift.sv
module rnd_shift #(
  parameter int unsigned DATA_W  = rnd_pkg::DEF_DATA_W,
  localparam int unsigned SH_W   = rnd_pkg::shamt_width(DATA_W),
  localparam int unsigned EXT_W  = rnd_pkg::ext_width(DATA_W)
) (
  input  logic [DATA_W-1:0] operand_i,
  input  logic [SH_W-1:0]   shamt_i,
  input  logic [EXT_W-1:0]  incr_i,
  output logic [DATA_W-1:0] res_o
);
  logic signed [EXT_W-1:0] ext_op;
  logic signed [EXT_W-1:0] sum;
  logic signed [EXT_W-1:0] shifted;

  always_comb begin
    ext_op  = $signed({{(EXT_W-DATA_W){operand_i[DATA_W-1]}}, operand_i});
    sum     = ext_op + $signed(incr_i);
    shifted = sum >>> shamt_i;
    res_o   = DATA_W'(shifted);
  end
endmodule

// File: rtl/rne_shift_right.sv
module rne_shift_right #(
  parameter int unsigned DATA_W  = rnd_pkg::DEF_DATA_W,
  localparam int unsigned SH_W   = rnd_pkg::shamt_width(DATA_W),
  localparam int unsigned EXT_W  = rnd_pkg::ext_width(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [SH_W-1:0]   shamt_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] res_o
);
  logic [EXT_W-1:0]  incr;
  logic [DATA_W-1:0] res_d;

  rnd_incr #(.DATA_W(DATA_W)) u_incr (
    .operand_i(operand_i),
    .shamt_i  (shamt_i),
    .incr_o   (incr)
  );

  rnd_shift #(.DATA_W(DATA_W)) u_shift (
    .operand_i(operand_i),
    .shamt_i  (shamt_i),
    .incr_i   (incr),
    .res_o    (res_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) res_o <= res_d;
    end
  end

  a_r2_valid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r2_valid_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(res_o));
  a_r3_zero_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && shamt_i == '0) |=> res_o == $past(operand_i));
  a_r8_sign_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !operand_i[DATA_W-1]) |=> !res_o[DATA_W-1]);
  a_r6_exact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && shamt_i != '0 && ((operand_i & ((DATA_W'(1) << shamt_i) - DATA_W'(1))) == '0))
    |=> res_o == DATA_W'($signed($past(operand_i)) >>> $past(shamt_i)));
endmodule

// File: tb/sim_rne_shift_right.sv
`timescale 1ns/1ps
module sim_rne_shift_right;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld_i = 1'b0;
  logic [31:0] op_i = '0;
  logic [4:0]  sh_i = '0;
  logic        vld_o;
  logic [31:0] res;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  rne_shift_right u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vld_i),
    .operand_i(op_i), .shamt_i(sh_i), .valid_o(vld_o), .res_o(res)
  );

  function automatic logic [31:0] ref_round(input logic [31:0] a, input int n);
    longint v, fl, rem, half;
    v = longint'($signed(a));
    if (n == 0) return a;
    fl   = v >>> n;
    rem  = v - (fl <<< n);
    half = longint'(1) <<< (n - 1);
    if (rem > half || (rem == half && fl[0])) fl = fl + 1;
    return fl[31:0];
  endfunction

  function automatic string req_of(input logic [31:0] a, input int n);
    longint v, m;
    v = longint'($signed(a));
    if (n == 0) return "R3";
    m = v & ((longint'(1) <<< n) - 1);
    if (m == 0) return "R6";
    if (m == (longint'(1) <<< (n - 1))) return "R5";
    return "R4";
  endfunction

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // drive at negedge, result is registered at next posedge, sample at following negedge
  task automatic run_one(input logic [31:0] a, input int n, input string rq);
    vld_i = 1'b1; op_i = a; sh_i = 5'(n);
    @(negedge clk);
    check("R2", {31'b0, vld_o}, 32'd1);
    check(rq, res, ref_round(a, n));
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] edges[12];
    logic [31:0] held;
    edges = '{32'h0, 32'h1, 32'hffffffff, 32'h7fffffff, 32'h80000000, 32'h55555555,
              32'haaaaaaaa, 32'h00000003, 32'hfffffffd, 32'h40000000, 32'hc0000000, 32'h12345678};
    repeat (2) @(negedge clk);
    check("R1", {31'b0, vld_o}, 32'd0);
    check("R1", res, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {31'b0, vld_o}, 32'd0);
    check("R1", res, 32'd0);

    // R8 extremes and edge patterns at every shift
    for (int n = 0; n < 32; n++)
      for (int i = 0; i < 12; i++) begin
        string rq;
        rq = (i == 3 || i == 4) ? "R8" : req_of(edges[i], n);
        run_one(edges[i], n, rq);
      end

    // R5 ties, positive and negative, odd and even k
    for (int n = 1; n < 31; n++)
      for (int k = -4; k <= 4; k++) begin
        longint t;
        t = (longint'(k) <<< n) + (longint'(1) <<< (n - 1));
        if (t <= 64'sh7fffffff && t >= -64'sh80000000) run_one(t[31:0], n, "R5");
      end

    // R6 exact multiples
    for (int n = 1; n < 31; n++)
      for (int k = -3; k <= 3; k++) begin
        longint t;
        t = longint'(k) <<< n;
        if (t <= 64'sh7fffffff && t >= -64'sh80000000) run_one(t[31:0], n, "R6");
      end

    // R4 random operands
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a;
      int n;
      a = $urandom;
      n = $urandom_range(0, 31);
      run_one(a, n, req_of(a, n));
    end

    // R7 hold with valid low
    run_one(32'h00000007, 1, "R5");
    held = res;
    vld_i = 1'b0;
    for (int i = 0; i < 8; i++) begin
      op_i = $urandom; sh_i = 5'($urandom_range(0, 31));
      @(negedge clk);
      check("R7", res, held);
      check("R2", {31'b0, vld_o}, 32'd0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule